// File: doc/BRIEF.md
# Elastic Multidrop Link with Escape Drain

This block is one direction of a point-to-multipoint on-chip link. The link has a chain of single-flit latch stages, one for each router it passes. The stages hold the traffic, so each router needs only a small buffer of its own. Every stage sits at a tap where its flit can leave into the local router. A flit travels forward one stage per cycle until it reaches the tap named in its destination field. Each packet is one flit, so bandwidth and storage are granted per packet. A node that drives four such links, one for each cardinal direction, instantiates this block four times.

The link carries two virtual channels. Each tap has a separate acceptance signal for each channel. A flit that its home router keeps refusing for `BLOCK_LIMIT` consecutive cycles counts as blocked. It is then marked for escape and sent on to the nearest downstream router that reports a free escape buffer, where it leaves with its destination field unchanged so it can be sent again later. This drain into an intermediate router prevents deadlock without a second network.

The entry port is a valid/ready stream. The sender holds the flit and its fields steady while `in_valid` is high and `in_ready` is low. `in_ready` does not depend on `in_valid`. A tap offers a flit with `drop_valid` whatever the router's acceptance, and keeps it steady until it is taken or marked for escape. For a normal flit the handshake is `drop_ready` for that flit's channel. For an escaping flit it is `esc_free` of that tap.

Top module: `ebm_link`

## Requirements
- R1: During reset and right after it every stage is empty: `drop_valid` is all zero and `in_ready` is 1.
- R2: A stage holds at most one flit. `in_ready` is 1 exactly when the first stage is empty or its flit leaves in the same cycle. An accepted flit is visible at stage 0 on the next cycle and moves forward one stage per cycle while the stage ahead can take it.
- R3: A normal flit raises `drop_valid[i]` only at the stage i that equals its destination field, and its `drop_escape[i]` is 0.
- R4: A flit that is refused stays in its stage with unchanged fields, and the flits behind it wait. No flit is lost, duplicated or reordered: every accepted flit is delivered exactly once.
- R5: The flit's channel bit selects its acceptance lane: at tap i, channel v is accepted by `drop_ready[2*i+v]`. The other lane has no effect on it.
- R6: When a normal flit has been refused at its home tap on `BLOCK_LIMIT` consecutive cycles, it is marked for escape at that clock edge if some tap j > i has `esc_free[j]` = 1. Its target is the smallest such j. Once marked it leaves the home tap (`drop_valid[i]` falls) and moves downstream.
- R7: If no downstream tap has a free escape buffer, the blocked flit stays offered at its home tap, and the escape search is repeated on every later refused cycle.
- R8: An escaping flit is offered at its target tap with `drop_escape` = 1 and is taken only when `esc_free` of that tap is 1. Its destination field, channel and data are unchanged. It never changes target.
- R9: An escaping flit is never delivered at its original destination. Its destination field is always lower than the tap that offers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Entry flit valid |
| in_vc | input | 1 | Entry flit virtual channel |
| in_dest | input | DEST_W | Entry flit destination tap (below NUM_DROPS) |
| in_data | input | DATA_W | Entry flit payload |
| drop_ready | input | 2*NUM_DROPS | Router acceptance, bit 2*i+v for tap i, channel v |
| esc_free | input | NUM_DROPS | Escape buffer at tap i can take a packet |
| in_ready | output | 1 | Link can take the entry flit |
| drop_valid | output | NUM_DROPS | Tap i offers a flit |
| drop_escape | output | NUM_DROPS | Offered flit at tap i is an escaping flit |
| drop_vc | output | NUM_DROPS | Channel of the flit at tap i |
| drop_dest | output | NUM_DROPS*DEST_W | Destination field of the flit at tap i |
| drop_data | output | NUM_DROPS*DATA_W | Payload of the flit at tap i |

## Verification
The hardest situation to reach is an escape: one tap must refuse a flit for the whole blocking window while a tap downstream happens to report a free escape buffer. A second hard case is the same refusal with every escape buffer full. The stimulus gets there in phases. In one phase a single tap refuses both channels continuously while the other taps accept and free escape space at random. In another phase every escape buffer is held full and one channel lane of a tap is refused most of the time. A behavioural model tracks each stage's occupancy and blocking count and is compared with every tap on every cycle. A final drain checks that every accepted flit came out exactly once.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
  typedef enum logic {
    LANE_NORMAL = 1'b0,
    LANE_ESCAPE = 1'b1
  } route_e;
endpackage

// File: rtl/ebm_esc_pick.sv
module ebm_esc_pick #(
  parameter int NUM_DROPS = 4,
  parameter int HERE      = 0,
  localparam int DEST_W   = $clog2(NUM_DROPS)
) (
  input  logic [NUM_DROPS-1:0] esc_free,
  output logic                 found,
  output logic [DEST_W-1:0]    tgt
);
  // scan from the far end so the nearest free tap overwrites the others
  always_comb begin
    found = 1'b0;
    tgt   = '0;
    for (int j = NUM_DROPS - 1; j >= 0; j--) begin
      if (j > HERE && esc_free[j]) begin
        found = 1'b1;
        tgt   = DEST_W'(j);
      end
    end
  end
endmodule

// File: rtl/ebm_stage.sv
module ebm_stage
  import ebm_pkg::*;
#(
  parameter int IDX         = 0,
  parameter int NUM_DROPS   = 4,
  parameter int DATA_W      = 16,
  parameter int BLOCK_LIMIT = 16,
  localparam int DEST_W     = $clog2(NUM_DROPS),
  localparam int CNT_W      = $clog2(BLOCK_LIMIT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  input  logic              up_vc,
  input  logic [DEST_W-1:0] up_dest,
  input  route_e            up_route,
  input  logic [DEST_W-1:0] up_tgt,
  input  logic [DATA_W-1:0] up_data,
  output logic              take_ok,
  input  logic              dn_take,
  input  logic [1:0]        lane_rdy,
  input  logic              esc_free_here,
  input  logic              esc_found,
  input  logic [DEST_W-1:0] esc_pick,
  output logic              q_valid,
  output logic              q_vc,
  output logic [DEST_W-1:0] q_dest,
  output route_e            q_route,
  output logic [DEST_W-1:0] q_tgt,
  output logic [DATA_W-1:0] q_data,
  output logic              exit_want,
  output logic              fwd_req
);
  localparam logic [DEST_W-1:0] HERE    = DEST_W'(IDX);
  localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(BLOCK_LIMIT - 1);

  logic [CNT_W-1:0] stall_cnt;
  logic exit_ok, fwd_ok, leaving, load, stalled, escaping;

  assign escaping  = (q_route == LANE_ESCAPE);
  assign exit_want = q_valid && (escaping ? (q_tgt == HERE) : (q_dest == HERE));
  assign exit_ok   = exit_want && (escaping ? esc_free_here : lane_rdy[q_vc]);
  assign fwd_req   = q_valid && !exit_want;
  assign fwd_ok    = fwd_req && dn_take;
  assign leaving   = exit_ok || fwd_ok;
  assign take_ok   = !q_valid || leaving;
  assign load      = up_valid && take_ok;
  assign stalled   = q_valid && !escaping && (q_dest == HERE) && !exit_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_vc      <= 1'b0;
      q_dest    <= '0;
      q_route   <= LANE_NORMAL;
      q_tgt     <= '0;
      q_data    <= '0;
      stall_cnt <= '0;
    end else if (load) begin
      q_valid   <= 1'b1;
      q_vc      <= up_vc;
      q_dest    <= up_dest;
      q_route   <= up_route;
      q_tgt     <= up_tgt;
      q_data    <= up_data;
      stall_cnt <= '0;
    end else if (leaving) begin
      q_valid   <= 1'b0;
      stall_cnt <= '0;
    end else if (stalled) begin
      if (stall_cnt == CNT_MAX) begin
        if (esc_found) begin
          q_route   <= LANE_ESCAPE;
          q_tgt     <= esc_pick;
          stall_cnt <= '0;
        end
      end else begin
        stall_cnt <= stall_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ebm_link.sv
module ebm_link
  import ebm_pkg::*;
#(
  parameter int NUM_DROPS   = 4,
  parameter int DATA_W      = 16,
  parameter int BLOCK_LIMIT = 16,
  localparam int DEST_W     = $clog2(NUM_DROPS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_vc,
  input  logic [DEST_W-1:0]           in_dest,
  input  logic [DATA_W-1:0]           in_data,
  input  logic [2*NUM_DROPS-1:0]      drop_ready,
  input  logic [NUM_DROPS-1:0]        esc_free,
  output logic                        in_ready,
  output logic [NUM_DROPS-1:0]        drop_valid,
  output logic [NUM_DROPS-1:0]        drop_escape,
  output logic [NUM_DROPS-1:0]        drop_vc,
  output logic [NUM_DROPS*DEST_W-1:0] drop_dest,
  output logic [NUM_DROPS*DATA_W-1:0] drop_data
);
  logic   [NUM_DROPS-1:0] take_ok, fwd_req, st_valid, st_vc, found;
  route_e                 st_route [NUM_DROPS];
  logic   [DEST_W-1:0]    st_dest  [NUM_DROPS];
  logic   [DEST_W-1:0]    st_tgt   [NUM_DROPS];
  logic   [DEST_W-1:0]    pick     [NUM_DROPS];
  logic   [DATA_W-1:0]    st_data  [NUM_DROPS];

  assign in_ready = take_ok[0];

  for (genvar i = 0; i < NUM_DROPS; i++) begin : g_stage
    logic              u_valid, u_vc, d_take;
    logic [DEST_W-1:0] u_dest, u_tgt;
    route_e            u_route;
    logic [DATA_W-1:0] u_data;

    if (i == 0) begin : g_head
      assign u_valid = in_valid;
      assign u_vc    = in_vc;
      assign u_dest  = in_dest;
      assign u_route = LANE_NORMAL;
      assign u_tgt   = '0;
      assign u_data  = in_data;
    end else begin : g_body
      assign u_valid = fwd_req[i-1];
      assign u_vc    = st_vc[i-1];
      assign u_dest  = st_dest[i-1];
      assign u_route = st_route[i-1];
      assign u_tgt   = st_tgt[i-1];
      assign u_data  = st_data[i-1];
    end

    if (i == NUM_DROPS - 1) begin : g_tail
      assign d_take = 1'b0;
    end else begin : g_mid
      assign d_take = take_ok[i+1];
    end

    ebm_esc_pick #(.NUM_DROPS(NUM_DROPS), .HERE(i)) u_pick (
      .esc_free (esc_free),
      .found    (found[i]),
      .tgt      (pick[i])
    );

    ebm_stage #(
      .IDX(i), .NUM_DROPS(NUM_DROPS), .DATA_W(DATA_W), .BLOCK_LIMIT(BLOCK_LIMIT)
    ) u_stage (
      .clk           (clk),
      .rst_n         (rst_n),
      .up_valid      (u_valid),
      .up_vc         (u_vc),
      .up_dest       (u_dest),
      .up_route      (u_route),
      .up_tgt        (u_tgt),
      .up_data       (u_data),
      .take_ok       (take_ok[i]),
      .dn_take       (d_take),
      .lane_rdy      (drop_ready[2*i +: 2]),
      .esc_free_here (esc_free[i]),
      .esc_found     (found[i]),
      .esc_pick      (pick[i]),
      .q_valid       (st_valid[i]),
      .q_vc          (st_vc[i]),
      .q_dest        (st_dest[i]),
      .q_route       (st_route[i]),
      .q_tgt         (st_tgt[i]),
      .q_data        (st_data[i]),
      .exit_want     (drop_valid[i]),
      .fwd_req       (fwd_req[i])
    );

    assign drop_escape[i]                = (st_route[i] == LANE_ESCAPE);
    assign drop_vc[i]                    = st_vc[i];
    assign drop_dest[i*DEST_W +: DEST_W] = st_dest[i];
    assign drop_data[i*DATA_W +: DATA_W] = st_data[i];
  end
endmodule

// File: rtl/ebm_link_chk.sv
module ebm_link_chk #(
  parameter int NUM_DROPS   = 4,
  parameter int DATA_W      = 16,
  localparam int DEST_W     = $clog2(NUM_DROPS)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [2*NUM_DROPS-1:0]      drop_ready,
  input logic [NUM_DROPS-1:0]        esc_free,
  input logic [NUM_DROPS-1:0]        drop_valid,
  input logic [NUM_DROPS-1:0]        drop_escape,
  input logic [NUM_DROPS-1:0]        drop_vc,
  input logic [NUM_DROPS*DEST_W-1:0] drop_dest,
  input logic [NUM_DROPS*DATA_W-1:0] drop_data
);
  for (genvar i = 0; i < NUM_DROPS; i++) begin : g_tap
    logic lane_ok;
    assign lane_ok = drop_ready[2*i + int'(drop_vc[i])];

    assert_refused_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_valid[i] && !drop_escape[i] && !lane_ok)
      |=> (!drop_valid[i] || $stable(drop_data[i*DATA_W +: DATA_W])));

    assert_escape_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_valid[i] && drop_escape[i] && !esc_free[i])
      |=> (drop_valid[i] && drop_escape[i] && $stable(drop_data[i*DATA_W +: DATA_W])));

    assert_home_tap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_valid[i] && !drop_escape[i])
      |-> (drop_dest[i*DEST_W +: DEST_W] == DEST_W'(i)));

    assert_escape_downstream_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_valid[i] && drop_escape[i])
      |-> (int'(drop_dest[i*DEST_W +: DEST_W]) < i));
  end
endmodule

bind ebm_link ebm_link_chk #(.NUM_DROPS(NUM_DROPS), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .drop_ready  (drop_ready),
  .esc_free    (esc_free),
  .drop_valid  (drop_valid),
  .drop_escape (drop_escape),
  .drop_vc     (drop_vc),
  .drop_dest   (drop_dest),
  .drop_data   (drop_data)
);

// File: tb/tb_ebm_link.sv
module tb_ebm_link;
  localparam int N   = 4;
  localparam int DW  = 8;
  localparam int LIM = 5;
  localparam int DEW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           in_valid = 1'b0, in_vc = 1'b0;
  logic [DEW-1:0] in_dest = '0;
  logic [DW-1:0]  in_data = '0;
  logic [2*N-1:0] drop_ready = '0;
  logic [N-1:0]   esc_free = '0;
  logic           in_ready;
  logic [N-1:0]   drop_valid, drop_escape, drop_vc;
  logic [N*DEW-1:0] drop_dest;
  logic [N*DW-1:0]  drop_data;

  ebm_link #(.NUM_DROPS(N), .DATA_W(DW), .BLOCK_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_dest(in_dest),
    .in_data(in_data), .drop_ready(drop_ready), .esc_free(esc_free), .in_ready(in_ready),
    .drop_valid(drop_valid), .drop_escape(drop_escape), .drop_vc(drop_vc),
    .drop_dest(drop_dest), .drop_data(drop_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  // behavioural model: per-tap occupancy record
  int mv[N], mvc[N], md[N], mdat[N], me[N], mt[N], mc[N];
  int want[N], exok[N], fwok[N], take[N];
  int n_sent = 0, n_out = 0, n_esc_out = 0, esc_ph3 = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_eval();
    for (int i = N - 1; i >= 0; i--) begin
      int dn;
      want[i] = (mv[i] != 0) && ((me[i] != 0) ? (mt[i] == i) : (md[i] == i));
      exok[i] = want[i] && ((me[i] != 0) ? int'(esc_free[i]) : int'(drop_ready[2*i+mvc[i]]));
      dn = (i == N - 1) ? 0 : take[i+1];
      fwok[i] = (mv[i] != 0) && !want[i] && dn;
      take[i] = (mv[i] == 0) || exok[i] || fwok[i];
    end
  endtask

  task automatic model_step();
    int nv[N], nvc[N], nd[N], ndat[N], ne[N], nt[N], nc[N];
    for (int i = 0; i < N; i++) begin
      int ld, stalled;
      nv[i] = mv[i]; nvc[i] = mvc[i]; nd[i] = md[i]; ndat[i] = mdat[i];
      ne[i] = me[i]; nt[i] = mt[i]; nc[i] = mc[i];
      ld = (i == 0) ? (in_valid && take[0]) : fwok[i-1];
      stalled = mv[i] && !me[i] && (md[i] == i) && !exok[i];
      if (ld) begin
        nv[i] = 1; nc[i] = 0;
        if (i == 0) begin
          nvc[i] = in_vc; nd[i] = in_dest; ndat[i] = in_data; ne[i] = 0; nt[i] = 0;
        end else begin
          nvc[i] = mvc[i-1]; nd[i] = md[i-1]; ndat[i] = mdat[i-1];
          ne[i] = me[i-1]; nt[i] = mt[i-1];
        end
      end else if (exok[i] || fwok[i]) begin
        nv[i] = 0; nc[i] = 0;
      end else if (stalled) begin
        if (mc[i] == LIM - 1) begin
          for (int j = i + 1; j < N; j++)
            if (esc_free[j] && ne[i] == 0) begin ne[i] = 1; nt[i] = j; nc[i] = 0; end
        end else nc[i] = mc[i] + 1;
      end
    end
    mv = nv; mvc = nvc; md = nd; mdat = ndat; me = ne; mt = nt; mc = nc;
  endtask

  task automatic compare_all();
    check(in_ready == take[0], "R2 in_ready", in_ready, take[0]);
    for (int i = 0; i < N; i++) begin
      check(drop_valid[i] == want[i], "R3 drop_valid", drop_valid[i], want[i]);
      if (mv[i] != 0) begin
        check(drop_escape[i] == me[i], "R6 drop_escape", drop_escape[i], me[i]);
        check(drop_vc[i] == mvc[i], "R5 drop_vc", drop_vc[i], mvc[i]);
        check(drop_dest[i*DEW +: DEW] == md[i], "R8 drop_dest", drop_dest[i*DEW +: DEW], md[i]);
        check(drop_data[i*DW +: DW] == mdat[i], "R4 drop_data", drop_data[i*DW +: DW], mdat[i]);
      end
    end
  endtask

  // port-level handshake tally
  task automatic tally(input int phase);
    if (in_valid && in_ready) n_sent++;
    for (int i = 0; i < N; i++) begin
      if (drop_valid[i] && drop_escape[i] && esc_free[i]) n_esc_out++;
      if (drop_valid[i] && (drop_escape[i] ? esc_free[i] : drop_ready[2*i+int'(drop_vc[i])]))
        n_out++;
      if (phase == 3 && drop_valid[i] && drop_escape[i]) esc_ph3++;
    end
  endtask

  task automatic drive(input int phase);
    if (!(in_valid && !in_ready)) begin
      in_valid = (phase == 2 || phase == 4) ? 1'b0 : ($urandom_range(0, 3) != 0);
      in_vc    = 1'($urandom);
      in_dest  = DEW'($urandom_range(0, N - 1));
      in_data  = DW'($urandom);
    end
    case (phase)
      1: begin
        for (int b = 0; b < 2*N; b++) drop_ready[b] = ($urandom_range(0, 3) != 0);
        esc_free = N'($urandom);
      end
      2, 4: begin
        drop_ready = '1; esc_free = '1;
      end
      3: begin
        for (int b = 0; b < 2*N; b++) drop_ready[b] = ($urandom_range(0, 4) != 0);
        if ($urandom_range(0, 9) < 7) drop_ready[4] = 1'b0;
        esc_free = '0;
      end
      default: begin
        for (int b = 0; b < 2*N; b++) drop_ready[b] = ($urandom_range(0, 3) != 0);
        drop_ready[2] = 1'b0; drop_ready[3] = 1'b0;
        esc_free = N'($urandom);
      end
    endcase
  endtask

  task automatic run(input int phase, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      drive(phase);
      #1;
      model_eval();
      compare_all();
      tally(phase);
      @(posedge clk);
      model_step();
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      mv[i] = 0; mvc[i] = 0; md[i] = 0; mdat[i] = 0; me[i] = 0; mt[i] = 0; mc[i] = 0;
    end
    repeat (2) @(negedge clk);
    drop_ready = '1; esc_free = '1;
    #1;
    check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    check(drop_valid == '0, "R1 drop_valid in reset", drop_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(drop_valid == '0, "R1 drop_valid after reset", drop_valid, 0);
    run(1, 300);  // mixed traffic, both channels
    run(5, 400);  // tap 1 refuses both lanes: escapes (R6, R7 retry)
    check(n_esc_out > 0, "R6 escapes delivered", n_esc_out, 1);
    run(2, 40);   // drain
    run(3, 300);  // escape buffers full, tap 2 lane 0 mostly refused
    check(esc_ph3 == 0, "R7 no escape without free buffer", esc_ph3, 0);
    run(4, 60);   // final drain
    check(drop_valid == '0, "R4 link empty after drain", drop_valid, 0);
    check(n_out == n_sent, "R4 every flit delivered once", n_out, n_sent);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule